// File: doc/BRIEF.md
# Strided Bit Gather Unit

The unit takes a 128-bit vector operand and a small stride N. Starting at the operand's most significant bit, it picks every Nth bit and packs the picked bits into a 64-bit scalar, most significant end first. All result bits below the last packed bit are zero. The operand is handled as two 64-bit doublewords, high half first. The stride runs on without a break from the high half into the low half.

The same unit decodes a 32-bit instruction word. From that word it takes the destination index, the source index and the stride, and it raises a match flag when the word is the gather operation. A stride of 0 or 1 is not a legal gather: the unit then holds its write enable low.

Each doubleword is compacted by a chain of six shift/mask/OR stages, one stage per bit of a bit's travel distance. The stages do not use per-bit wiring or a loop over the bits. Results are registered, so they appear one cycle after the inputs.

Top module: `stride_gather_unit`

## Requirements
- R1: `out_match` is high only for a valid input word whose bits 31:26 equal 000100 and whose bits 10:0 equal 10011001100. `out_wr_en` is never high without `out_match`.
- R2: For a matching word, `out_rt` equals instruction bits 25:21 and `out_vrb` equals bits 15:11. The stride is read from bits 18:16. Bits 20:19 have no effect on any output.
- R3: For a matching word with a stride of 0 or 1, `out_wr_en` is low and `out_result` is zero, while `out_match` stays high.
- R4: For a legal stride N (2 to 7), result bit 63−k equals operand bit 127−k·N for every k with k·N < 128. Operand bit 127 is the first picked bit.
- R5: Selection continues across the doubleword boundary. The first bit picked from the low doubleword (operand bits 63:0) lies ceil(64/N)·N − 64 positions below its top bit.
- R6: For a legal stride N, result bits 63−ceil(128/N) down to 0 are zero. With N = 2, all 64 result bits carry operand bits.
- R7: When `in_valid` is low, or the word does not match, `out_match` and `out_wr_en` are low and `out_result` is zero.
- R8: Outputs are registered. Each output reflects the inputs present at the previous rising clock edge, and `out_valid` is `in_valid` delayed by one cycle.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operand are present |
| in_instr | input | 32 | Instruction word to decode |
| in_operand | input | 128 | Vector operand, bit 127 is its first bit |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_match | output | 1 | Word is the gather operation |
| out_wr_en | output | 1 | Result may be written (match and legal stride) |
| out_rt | output | 5 | Destination index field |
| out_vrb | output | 5 | Source index field |
| out_result | output | 64 | Packed gathered bits, zero-filled below |

## Verification
The assertions check on every cycle that:
- the one-cycle latency of `out_valid` holds;
- no write occurs without a match or with a stride below two;
- the lead result bit always equals the operand's top bit;
- the last result bit at stride two and the zero tail at stride seven match the operand.

Exact packing for every stride can only be shown by the bench's scenarios, which compare each cycle against a bit-loop model. This includes the position where the low doubleword's selection resumes. The scenarios use walking single bits, dense patterns and random operands, with random ignored fields and mismatching words.

// File: rtl/gather_pkg.sv
package gather_pkg;
    localparam int WORD_W     = 32;
    localparam int DW         = 64;
    localparam int OPND_W     = 2 * DW;
    localparam int STRIDE_W   = 3;
    localparam int REG_W      = 5;
    localparam int STAGES     = $clog2(DW);
    localparam int MIN_STRIDE = 2;
    localparam int MAX_STRIDE = (1 << STRIDE_W) - 1;

    localparam logic [5:0]  PRIMARY_OP = 6'b000100;
    localparam logic [10:0] MINOR_OP   = 11'b10011001100;

    typedef struct packed {
        logic                match;
        logic                legal;
        logic [REG_W-1:0]    rt;
        logic [REG_W-1:0]    vrb;
        logic [STRIDE_W-1:0] stride;
    } gather_dec_t;

    // bits taken from the high doubleword for stride n
    function automatic int lead_count(int n);
        return (DW + n - 1) / n;
    endfunction

    // big-endian position of the first selected bit in a doubleword
    function automatic int start_pos(int n, bit low_half);
        return low_half ? lead_count(n) * n - DW : 0;
    endfunction
endpackage

// File: rtl/gather_decode.sv
module gather_decode
    import gather_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output gather_dec_t       dec
);
    logic unused_spare;
    assign unused_spare = ^instr[20:19];

    always_comb begin
        dec.match  = (instr[31:26] == PRIMARY_OP) && (instr[10:0] == MINOR_OP);
        dec.rt     = instr[25:21];
        dec.stride = instr[18:16];
        dec.vrb    = instr[15:11];
        dec.legal  = dec.match && (int'(dec.stride) >= MIN_STRIDE);
    end
endmodule

// File: rtl/stride_dword_pack.sv
module stride_dword_pack
    import gather_pkg::*;
#(
    parameter bit LOW_HALF = 1'b0
) (
    input  logic [DW-1:0]       dword,
    input  logic [STRIDE_W-1:0] stride,
    output logic [DW-1:0]       pack_out
);
    // tables indexed by big-endian position (0 = most significant bit)
    logic [DW-1:0]     sel_tab  [MAX_STRIDE+1];
    logic [STAGES-1:0] disp_tab [MAX_STRIDE+1][DW];

    for (genvar n = 0; n <= MAX_STRIDE; n++) begin : g_stride
        for (genvar i = 0; i < DW; i++) begin : g_pos
            localparam int  P0   = (n >= MIN_STRIDE) ? start_pos(n, LOW_HALF) : 0;
            localparam bit  HIT  = (n >= MIN_STRIDE) && (i >= P0) && (((i - P0) % ((n >= MIN_STRIDE) ? n : 1)) == 0);
            localparam int  MOVE = HIT ? i - (i - P0) / ((n >= MIN_STRIDE) ? n : 1) : 0;
            assign sel_tab[n][i]  = HIT;
            assign disp_tab[n][i] = STAGES'(MOVE);
        end
    end

    logic [DW-1:0]     pres [STAGES+1];
    logic [DW-1:0]     dat  [STAGES+1];
    logic [STAGES-1:0] dsp  [STAGES+1][DW];

    for (genvar i = 0; i < DW; i++) begin : g_load
        assign pres[0][i] = sel_tab[stride][i];
        assign dat[0][i]  = sel_tab[stride][i] & dword[DW-1-i];
        assign dsp[0][i]  = disp_tab[stride][i];
        assign pack_out[DW-1-i] = dat[STAGES][i];
    end

    // stage s moves a bit 2**s places toward the MSB when bit s of its distance is set
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int SH = 1 << s;
        for (genvar i = 0; i < DW; i++) begin : g_cell
            logic arr_p, arr_d, keep;
            logic [STAGES-1:0] arr_x;
            if (i + SH < DW) begin : g_nb
                assign arr_p = pres[s][i+SH] & dsp[s][i+SH][s];
                assign arr_d = dat[s][i+SH];
                assign arr_x = dsp[s][i+SH];
            end else begin : g_edge
                assign arr_p = 1'b0;
                assign arr_d = 1'b0;
                assign arr_x = '0;
            end
            assign keep          = pres[s][i] & ~dsp[s][i][s];
            assign pres[s+1][i]  = keep | arr_p;
            assign dat[s+1][i]   = keep ? dat[s][i] : (arr_p & arr_d);
            assign dsp[s+1][i]   = keep ? dsp[s][i] : arr_x;
        end
    end
endmodule

// File: rtl/stride_gather_unit.sv
module stride_gather_unit
    import gather_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     in_instr,
    input  logic [OPND_W-1:0]     in_operand,
    output logic                  out_valid,
    output logic                  out_match,
    output logic                  out_wr_en,
    output logic [REG_W-1:0]      out_rt,
    output logic [REG_W-1:0]      out_vrb,
    output logic [DW-1:0]         out_result
);
    localparam int CNT_W = $clog2(DW) + 1;
    localparam int TAIL7 = DW - (OPND_W + MAX_STRIDE - 1) / MAX_STRIDE;

    gather_dec_t   dec;
    logic [DW-1:0] hi_p, lo_p, gather_word, next_result;
    logic [CNT_W-1:0] hi_cnt;

    gather_decode u_dec (.instr(in_instr), .dec(dec));

    stride_dword_pack #(.LOW_HALF(1'b0)) u_hi (
        .dword(in_operand[OPND_W-1:DW]), .stride(dec.stride), .pack_out(hi_p));
    stride_dword_pack #(.LOW_HALF(1'b1)) u_lo (
        .dword(in_operand[DW-1:0]), .stride(dec.stride), .pack_out(lo_p));

    always_comb begin
        hi_cnt = '0;
        for (int n = MIN_STRIDE; n <= MAX_STRIDE; n++) begin
            if (int'(dec.stride) == n) hi_cnt = CNT_W'(lead_count(n));
        end
        gather_word = hi_p | (lo_p >> hi_cnt);
        next_result = (in_valid && dec.legal) ? gather_word : '0;
    end

    if (REGISTER_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid  <= 1'b0;
                out_match  <= 1'b0;
                out_wr_en  <= 1'b0;
                out_rt     <= '0;
                out_vrb    <= '0;
                out_result <= '0;
            end else begin
                out_valid  <= in_valid;
                out_match  <= in_valid & dec.match;
                out_wr_en  <= in_valid & dec.legal;
                out_rt     <= dec.rt;
                out_vrb    <= dec.vrb;
                out_result <= next_result;
            end
        end

        assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
        assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> (!out_match && !out_wr_en));
        assert_write_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_wr_en |-> out_match);
        assert_illegal_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && int'($past(in_instr[18:16])) < MIN_STRIDE) |-> !out_wr_en);
        assert_lead_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_wr_en |-> out_result[DW-1] == $past(in_operand[OPND_W-1]));
        assert_full_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_wr_en && $past(in_instr[18:16]) == 3'd2) |-> out_result[0] == $past(in_operand[1]));
        assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_wr_en && int'($past(in_instr[18:16])) == MAX_STRIDE) |-> out_result[TAIL7-1:0] == '0);
    end else begin : g_comb
        always_comb begin
            out_valid  = in_valid;
            out_match  = in_valid & dec.match;
            out_wr_en  = in_valid & dec.legal;
            out_rt     = dec.rt;
            out_vrb    = dec.vrb;
            out_result = next_result;
        end
    end
endmodule

// File: tb/stride_gather_unit_bench.sv
module stride_gather_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_operand = '0;
    logic         out_valid, out_match, out_wr_en;
    logic [4:0]   out_rt, out_vrb;
    logic [63:0]  out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stride_gather_unit u_stride_gather_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_operand(in_operand), .out_valid(out_valid), .out_match(out_match),
        .out_wr_en(out_wr_en), .out_rt(out_rt), .out_vrb(out_vrb), .out_result(out_result));

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_gather(logic [127:0] op, int n);
        logic [63:0] r = '0;
        for (int k = 0; k * n < 128; k++) r[63-k] = op[127-k*n];
        return r;
    endfunction

    function automatic logic [31:0] mk_instr(logic [4:0] rt, logic [1:0] ign, logic [2:0] n, logic [4:0] vrb);
        return {6'b000100, rt, ign, n, vrb, 11'b10011001100};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // drive at a falling edge, then compare one cycle later at the next falling edge
    task automatic step(logic v, logic [31:0] ins, logic [127:0] op);
        logic m, w;
        logic [63:0] er;
        in_valid = v; in_instr = ins; in_operand = op;
        m  = v && ins[31:26] == 6'b000100 && ins[10:0] == 11'b10011001100;
        w  = m && ins[18:16] >= 3'd2;
        er = w ? ref_gather(op, int'(ins[18:16])) : 64'd0;
        @(negedge clk);
        check(out_valid == v, "R8 valid", 64'(out_valid), 64'(v));
        check(out_match == m, "R1/R7 match", 64'(out_match), 64'(m));
        check(out_wr_en == w, "R3 wr_en", 64'(out_wr_en), 64'(w));
        if (m) begin
            check(out_rt == ins[25:21], "R2 rt", 64'(out_rt), 64'(ins[25:21]));
            check(out_vrb == ins[15:11], "R2 vrb", 64'(out_vrb), 64'(ins[15:11]));
        end
        if (w) check(out_result == er, "R4/R5/R6 result", out_result, er);
        else if (m) check(out_result == er, "R3 result", out_result, er);
        else check(out_result == er, "R7 result", out_result, er);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs zero while reset is held
        check(out_valid == 0 && out_match == 0 && out_wr_en == 0, "R9 flags", 64'({out_valid, out_match, out_wr_en}), 64'd0);
        check(out_result == 0 && out_rt == 0 && out_vrb == 0, "R9 data", out_result, 64'd0);
        rst_n = 1'b1;

        // every stride with dense and sparse patterns
        for (int n = 0; n < 8; n++) begin
            step(1'b1, mk_instr(5'(n + 3), 2'(n), 3'(n), 5'(31 - n)), {128{1'b1}});
            step(1'b1, mk_instr(5'd7, 2'd3, 3'(n), 5'd9), {32{4'b1010}});
            step(1'b1, mk_instr(5'd1, 2'd0, 3'(n), 5'd2), rnd128());
        end
        // R5: walking single bits through the doubleword boundary region
        for (int n = 2; n < 8; n++) begin
            for (int p = 56; p < 76; p++) begin
                logic [127:0] op = '0;
                op[127-p] = 1'b1;
                step(1'b1, mk_instr(5'd4, 2'(p), 3'(n), 5'd5), op);
            end
        end
        // R6: last position for each stride
        for (int n = 2; n < 8; n++) begin
            step(1'b1, mk_instr(5'd0, 2'd1, 3'(n), 5'd0), 128'd1);
            step(1'b1, mk_instr(5'd0, 2'd2, 3'(n), 5'd0), 128'd1 << (n - 1));
        end
        // R2: ignored bits do not matter
        for (int g = 0; g < 4; g++) begin
            step(1'b1, mk_instr(5'd12, 2'(g), 3'd3, 5'd17), {4{32'hC3A5_0F1E}});
        end
        // R7: mismatching words and idle cycles
        step(1'b1, mk_instr(5'd3, 2'd0, 3'd2, 5'd3) ^ 32'h0400_0000, rnd128());
        step(1'b1, mk_instr(5'd3, 2'd0, 3'd2, 5'd3) ^ 32'h0000_0001, rnd128());
        step(1'b0, mk_instr(5'd3, 2'd0, 3'd2, 5'd3), rnd128());
        // random stream
        for (int t = 0; t < 2000; t++) begin
            logic [31:0] ins = mk_instr(5'($urandom), 2'($urandom), 3'($urandom), 5'($urandom));
            if ($urandom_range(0, 7) == 0) ins = $urandom;
            step(1'($urandom_range(0, 3) != 0), ins, rnd128());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule